// File: doc/BRIEF.md
# Tagged-Word UART Receiver

This block takes an asynchronous serial line, oversamples it with a sample-rate strobe at sixteen times the bit rate, and rebuilds characters from it. The character layout (data length, parity mode, stop count) comes from the same frame fields that the companion transmitter reads. The receiver validates the start bit at its midpoint and samples every data bit at its centre. It then checks parity and the first stop bit. Each finished character is stored in a two-entry queue together with its own parity-error and framing-error tags.

The reader sees the head of the queue as one 16-bit word that carries the data and both error tags, and pulses a read strobe to drop that entry. A level output reports that data is waiting. Two sticky interrupt flags record arrivals and overflows. Software can set or clear these flags with bit masks, and an enable mask gates them onto one interrupt line. Command strobes switch the receiver on and off.

A line held low for a whole character, which is a break, yields exactly one entry: a framing error with all-zero data. The receiver then waits for the line to go high before it looks for a new start bit.

Top module: `uart_rx_tagged`

## Requirements
- R1: The readout word holds the received data in bits 8:0, the parity-error tag in bit 14 and the framing-error tag in bit 15. Bits 13:9 always read zero, and the whole word is zero while the queue is empty.
- R2: For a data length below nine bits, the unused upper data bits of the readout word are zero.
- R3: `cfg_len` gives the number of data bits, from 4 to 9. Bits are sent LSB first. `cfg_parity` selects the parity mode: 2'b00 or 2'b01 means no parity, 2'b10 means even and 2'b11 means odd. The parity bit follows the last data bit.
- R4: A parity bit that does not match the selected even or odd mode sets bit 14 of that character's word. With no parity the bit is always zero.
- R5: Only the first stop bit is checked. If it is low, bit 15 is set. With `cfg_two_stop` high, a low second stop slot is not reported and does not start a new character.
- R6: A break yields one entry, 16'h8000 for eight data bits with no parity. No further character is accepted until the line has been high.
- R7: A start bit is accepted only if the line is still low at the 8th sample tick after the falling edge. Shorter low pulses produce no character.
- R8: The queue holds two characters. `rx_valid` is high while at least one is stored. A read strobe removes the head entry, and a read strobe on an empty queue changes nothing.
- R9: A character that completes while the queue is full, with no read in that cycle, is discarded. The stored entries are kept and flag bit 1 (overflow) is set.
- R10: `irq_flags` bit 0 is set when a character is stored and bit 1 is set on overflow. Both are sticky. `if_set` sets bits, and `if_clr` clears bits unless a set occurs in the same cycle. `irq` is high when any flag bit is set together with its `if_en` bit.
- R11: The receiver is off after reset. `rx_en_cmd` switches it on and `rx_dis_cmd` switches it off, with disable winning when both are pulsed. While off, the line is ignored and stored entries are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Strobe at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high |
| cfg_len | input | 4 | Data bits per character (4..9) |
| cfg_parity | input | 2 | Parity mode |
| cfg_two_stop | input | 1 | Two stop bits per character |
| rx_en_cmd | input | 1 | Receiver enable strobe |
| rx_dis_cmd | input | 1 | Receiver disable strobe |
| rd_stb | input | 1 | Read strobe, pops the head entry |
| rd_word | output | 16 | Head entry with error tags |
| rx_valid | output | 1 | Queue not empty |
| if_set | input | 2 | Flag set mask |
| if_clr | input | 2 | Flag clear mask |
| if_en | input | 2 | Flag-to-interrupt enable mask |
| irq_flags | output | 2 | Sticky flags: bit 0 data stored, bit 1 overflow |
| irq | output | 1 | Gated interrupt |
| rx_active | output | 1 | Receiver is on |

## Verification
Overflow is the hardest state to reach, because a third character has to finish while two stored entries are still unread. The bench turns its reading monitor off, sends three back-to-back frames, and checks the overflow flag. It then turns the monitor back on so that exactly the first two characters come out. The second-stop and break cases also need line patterns that stay low across the point where a naive receiver would see a new start edge. The bench waits afterwards to confirm that no extra character appears.

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged #(
  parameter int OVS = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_tick,
  input  logic        rxd,
  input  logic [3:0]  cfg_len,
  input  logic [1:0]  cfg_parity,
  input  logic        cfg_two_stop,
  input  logic        rx_en_cmd,
  input  logic        rx_dis_cmd,
  input  logic        rd_stb,
  output logic [15:0] rd_word,
  output logic        rx_valid,
  input  logic [1:0]  if_set,
  input  logic [1:0]  if_clr,
  input  logic [1:0]  if_en,
  output logic [1:0]  irq_flags,
  output logic        irq,
  output logic        rx_active
);
  localparam int CW = $clog2(OVS);
  localparam int DW = 9;
  localparam int EW = DW + 2;
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    bidx;
  logic [DW-1:0] shreg;
  logic          par_bit, hi_seen, rx_on;
  logic          sync1, rxd_s;

  logic [3:0] eff_len;
  assign eff_len = (cfg_len < 4'd4) ? 4'd4 : (cfg_len > 4'd9) ? 4'd9 : cfg_len;

  wire par_en  = cfg_parity[1];
  wire running = rx_on && !rx_dis_cmd;
  wire at_last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      sync1 <= rxd;
      rxd_s <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on   <= 1'b0;
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      hi_seen <= 1'b0;
    end else begin
      if (rx_dis_cmd)     rx_on <= 1'b0;
      else if (rx_en_cmd) rx_on <= 1'b1;
      if (!running) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (sample_tick) begin
        case (st)
          S_IDLE: begin
            if (rxd_s) hi_seen <= 1'b1;
            else if (hi_seen) begin
              st      <= S_START;
              cnt     <= '0;
              hi_seen <= 1'b0;
              shreg   <= '0;
              bidx    <= '0;
            end
          end
          S_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              st  <= rxd_s ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (at_last) begin
              cnt         <= '0;
              shreg[bidx] <= rxd_s;
              bidx        <= bidx + 4'd1;
              if (bidx == eff_len - 4'd1) st <= par_en ? S_PAR : S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (at_last) begin
              cnt     <= '0;
              par_bit <= rxd_s;
              st      <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (at_last) begin
              cnt <= '0;
              st  <= cfg_two_stop ? S_STOP2 : S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP2: begin
            if (at_last) begin
              cnt <= '0;
              st  <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  wire push     = running && sample_tick && (st == S_STOP) && at_last;
  wire ferr_now = !rxd_s;
  wire perr_now = par_en && ((^shreg) ^ par_bit ^ cfg_parity[0]);

  logic [EW-1:0] mem [2];
  logic          wp, rp;
  logic [1:0]    count;

  wire pop    = rd_stb && (count != 2'd0);
  wire accept = push && ((count != 2'd2) || pop);
  wire ovf    = push && !accept;

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= {ferr_now, perr_now, shreg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= 1'b0;
      rp    <= 1'b0;
      count <= '0;
    end else begin
      if (accept) wp <= ~wp;
      if (pop)    rp <= ~rp;
      case ({accept, pop})
        2'b10:   count <= count + 2'd1;
        2'b01:   count <= count - 2'd1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flags <= '0;
    else        irq_flags <= (irq_flags & ~if_clr) | if_set | {ovf, accept};
  end

  logic [EW-1:0] head;
  assign head      = mem[rp];
  assign rx_valid  = (count != 2'd0);
  assign rd_word   = rx_valid ? {head[EW-1], head[EW-2], 5'd0, head[DW-1:0]} : 16'h0000;
  assign irq       = |(irq_flags & if_en);
  assign rx_active = rx_on;
endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_stb,
  input logic [15:0] rd_word,
  input logic        rx_valid,
  input logic [1:0]  if_set,
  input logic [1:0]  if_en,
  input logic [1:0]  irq_flags,
  input logic        irq,
  input logic        rx_dis_cmd,
  input logic        rx_active,
  input logic [1:0]  count
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[13:9] == 5'd0); // R1
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= 2'd2); // R8
  AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rd_stb |=> rx_valid); // R9
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|if_set) |=> ((irq_flags & $past(if_set)) == $past(if_set))); // R10
  AST_VALID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> irq_flags[0]); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (|if_en)); // R10
  AST_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dis_cmd |=> !rx_active); // R11
endmodule

bind uart_rx_tagged uart_rx_tagged_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_word(rd_word),
  .rx_valid(rx_valid), .if_set(if_set), .if_en(if_en),
  .irq_flags(irq_flags), .irq(irq), .rx_dis_cmd(rx_dis_cmd),
  .rx_active(rx_active), .count(count)
);

// File: tb/tb_uart_rx_tagged.sv
module tb_uart_rx_tagged;
  localparam int CLK_PERIOD = 10;
  localparam int BITCYC = 32;

  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0, rxd = 1'b1;
  logic [3:0] cfg_len = 4'd8;
  logic [1:0] cfg_parity = 2'b00;
  logic cfg_two_stop = 1'b0, rx_en_cmd = 1'b0, rx_dis_cmd = 1'b0;
  logic mon_rd = 1'b0, man_rd = 1'b0, mon_on = 1'b1;
  logic [1:0] if_set = 2'b00, if_clr = 2'b00, if_en = 2'b00;
  wire rd_stb = mon_rd | man_rd;
  wire [15:0] rd_word;
  wire rx_valid, irq, rx_active;
  wire [1:0] irq_flags;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  uart_rx_tagged dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .rx_en_cmd(rx_en_cmd), .rx_dis_cmd(rx_dis_cmd), .rd_stb(rd_stb),
    .rd_word(rd_word), .rx_valid(rx_valid), .if_set(if_set), .if_clr(if_clr),
    .if_en(if_en), .irq_flags(irq_flags), .irq(irq), .rx_active(rx_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) sample_tick <= ~sample_tick;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rx_valid && !mon_rd) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected character", rd_word, 16'h0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rd_word == e, t, rd_word, e);
        end
        mon_rd = 1'b1;
      end else mon_rd = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 16'h0, 16'h0);
    summary();
  end

  task automatic drive_bit(input logic b);
    @(negedge clk) rxd = b;
    repeat (BITCYC - 1) @(negedge clk);
  endtask

  task automatic send_frame(input int len, input logic [8:0] d, input logic [1:0] par,
                            input bit two, input bit flip, input bit stop1, input bit stop2,
                            input bit want, input string tag);
    logic [8:0] md;
    logic p;
    md = d & 9'((1 << len) - 1);
    p = ^md;
    if (par == 2'b11) p = ~p;
    if (flip) p = ~p;
    if (want) begin
      exp_q.push_back({~stop1, flip & par[1], 5'b0, md});
      tag_q.push_back(tag);
    end
    cfg_len = 4'(len); cfg_parity = par; cfg_two_stop = two;
    drive_bit(1'b0);
    for (int i = 0; i < len; i++) drive_bit(md[i]);
    if (par[1]) drive_bit(p);
    drive_bit(stop1);
    if (two) drive_bit(stop2);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && !rx_valid, tag, 16'(exp_q.size()), 16'h0);
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic pulse_cmd(input bit en, input bit dis);
    @(negedge clk) begin rx_en_cmd = en; rx_dis_cmd = dis; end
    @(negedge clk) begin rx_en_cmd = 1'b0; rx_dis_cmd = 1'b0; end
  endtask

  task automatic pulse_flags(input logic [1:0] s, input logic [1:0] c);
    @(negedge clk) begin if_set = s; if_clr = c; end
    @(negedge clk) begin if_set = 2'b00; if_clr = 2'b00; end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_word == 16'h0 && !rx_valid, "R8 reset empty", rd_word, 16'h0);
    check(irq_flags == 2'b00 && !irq, "R10 reset flags", 16'(irq_flags), 16'h0);
    check(!rx_active, "R11 reset off", 16'(rx_active), 16'h0);

    send_frame(8, 9'h5A, 2'b00, 0, 0, 1, 1, 0, "R11");
    check(!rx_valid, "R11 ignored while off", 16'(rx_valid), 16'h0);
    pulse_cmd(1, 1);
    check(!rx_active, "R11 disable wins", 16'(rx_active), 16'h0);
    pulse_cmd(1, 0);
    check(rx_active, "R11 enable", 16'(rx_active), 16'h1);
    repeat (BITCYC) @(negedge clk);

    send_frame(8, 9'h0A5, 2'b00, 0, 0, 1, 1, 1, "R1 8N1 word");
    send_frame(9, 9'h1C3, 2'b10, 0, 0, 1, 1, 1, "R3 9 bits even");
    send_frame(5, 9'h013, 2'b11, 0, 0, 1, 1, 1, "R3 5 bits odd");
    send_frame(4, 9'h00F, 2'b01, 0, 0, 1, 1, 1, "R3 4 bits mode01 none");
    send_frame(6, 9'h1FF, 2'b00, 0, 0, 1, 1, 1, "R2 upper bits zero");
    send_frame(8, 9'h036, 2'b10, 0, 1, 1, 1, 1, "R4 even parity error");
    send_frame(7, 9'h055, 2'b11, 0, 1, 1, 1, 1, "R4 odd parity error");
    send_frame(8, 9'h081, 2'b00, 0, 0, 0, 1, 1, "R5 framing error");
    send_frame(7, 9'h02C, 2'b10, 1, 0, 1, 0, 1, "R5 second stop ignored");
    drain("R5 no extra character");

    exp_q.push_back(16'h8000); tag_q.push_back("R6 break word");
    cfg_len = 4'd8; cfg_parity = 2'b00; cfg_two_stop = 1'b0;
    @(negedge clk) rxd = 1'b0;
    repeat (14 * BITCYC) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCYC) @(negedge clk);
    drain("R6 single break entry");

    @(negedge clk) rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCYC) @(negedge clk);
    check(!rx_valid, "R7 short glitch rejected", 16'(rx_valid), 16'h0);

    check(irq_flags[0], "R10 data flag sticky", 16'(irq_flags), 16'h1);
    @(negedge clk) if_en = 2'b01;
    @(negedge clk);
    check(irq, "R10 irq gated on", 16'(irq), 16'h1);
    pulse_flags(2'b00, 2'b11);
    check(irq_flags == 2'b00 && !irq, "R10 clear mask", 16'(irq_flags), 16'h0);
    pulse_flags(2'b10, 2'b00);
    check(irq_flags == 2'b10 && !irq, "R10 set mask, not enabled", 16'({irq, irq_flags}), 16'h2);
    @(negedge clk) if_en = 2'b10;
    @(negedge clk);
    check(irq, "R10 overflow irq enabled", 16'(irq), 16'h1);
    pulse_flags(2'b00, 2'b11);
    @(negedge clk) if_en = 2'b00;

    mon_on = 1'b0;
    send_frame(8, 9'h011, 2'b00, 0, 0, 1, 1, 0, "R9");
    send_frame(8, 9'h022, 2'b00, 0, 0, 1, 1, 0, "R9");
    check(rx_valid && irq_flags == 2'b01, "R8 two entries, no overflow", 16'(irq_flags), 16'h1);
    send_frame(8, 9'h033, 2'b00, 0, 0, 1, 1, 0, "R9");
    check(irq_flags[1], "R9 overflow flag", 16'(irq_flags), 16'h3);
    exp_q.push_back(16'h0011); tag_q.push_back("R9 first kept");
    exp_q.push_back(16'h0022); tag_q.push_back("R9 second kept");
    mon_on = 1'b1;
    drain("R9 third discarded");

    mon_on = 1'b0;
    @(negedge clk) man_rd = 1'b1;
    @(negedge clk) man_rd = 1'b0;
    check(!rx_valid && rd_word == 16'h0, "R8 read on empty", rd_word, 16'h0);
    mon_on = 1'b1;

    summary();
  end
endmodule